// File: doc/BRIEF.md
# Band-Limited Tuning Word Accumulator

This block is the digital core of a direct digital synthesizer whose output frequency is steered cycle by cycle by an external controller, typically the loop filter of a digital PLL. Each new 48-bit frequency tuning word is pushed through a two-sided saturating limiter before it reaches the phase accumulator. This keeps the synthesized tone inside a band chosen by software. A tight band lets a narrow analog band-pass filter follow the converter while the feedback tone stays within its passband.

The limited word is registered and then added to a 48-bit phase accumulator on every sample clock. The accumulator wraps freely. The top phase bits index a quarter-wave sine table, which uses symmetry to rebuild the full wave as a signed amplitude for a DAC. Two flags tell the controller whether the last accepted word was clipped at the top of the band or at the bottom.

Top module: `dds_tuning_core`

## Requirements
- R1: Reset clears the phase, the amplitude and both flags. It sets the upper limit to 2^47 (half the sample rate) and the lower limit to 0, so any word above 2^47 is clipped to 2^47.
- R2: A word above the upper limit is applied as the upper limit, and clip_hi is raised.
- R3: A word below the lower limit is applied as the lower limit, and clip_lo is raised (when lower ≤ upper).
- R4: A word within the limits, including a word exactly equal to either limit, is applied unchanged with both flags low. Narrow windows (nominal ± small offset) work.
- R5: Comparisons are unsigned. If the lower limit exceeds the upper, the applied word is the upper limit whenever max(word, lower) exceeds the upper limit; in that case clip_hi=1 and clip_lo=0. The two flags are never high together.
- R6: A word presented with ftw_valid at a clock edge is held in a register. It drives the accumulator from the next edge onward, and it is kept while ftw_valid is low.
- R7: On each clock, phase becomes phase + applied word, modulo 2^48.
- R8: amp is 14-bit two's complement. It equals round(8191·sin(2π(p+0.5)/4096)), where p = phase[47:36] as it was two clocks earlier.
- R9: With lim_wr high, lim_data is written to the upper limit when lim_sel=1 and to the lower limit when lim_sel=0. A write changes the applied word only at the next ftw_valid and never disturbs the phase.
- R10: clip_hi and clip_lo change only on an ftw_valid edge and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ftw_in | input | 48 | Incoming frequency tuning word |
| ftw_valid | input | 1 | Accept ftw_in at this edge |
| lim_wr | input | 1 | Limit register write strobe |
| lim_sel | input | 1 | 1 = upper limit, 0 = lower limit |
| lim_data | input | 48 | Limit value to write |
| phase | output | 48 | Phase accumulator value |
| amp | output | 14 | Signed sine amplitude |
| clip_hi | output | 1 | Last accepted word clipped at upper limit |
| clip_lo | output | 1 | Last accepted word clipped at lower limit |

## Verification
The flags are due one edge after an ftw_valid edge. The phase starts advancing by the new applied word on the edge after that. The amplitude follows the phase by two further edges. All inputs are driven and all outputs sampled on falling edges. The applied word is measured as the phase difference between two consecutive falling-edge samples, taken one full cycle after the flag sample. Each amplitude sample is compared with the sine of the phase sample recorded two falling edges earlier, so every check lands in the cycle its result is due.

// File: rtl/dds_pkg.sv
package dds_pkg;
    localparam int FTW_W = 48;
    localparam int PH_W  = 12;
    localparam int AMP_W = 14;

    typedef logic [FTW_W-1:0] ftw_t;

    typedef enum logic {
        SEL_FLOOR = 1'b0,
        SEL_CEIL  = 1'b1
    } lim_sel_e;

    typedef struct packed {
        ftw_t word;
        logic hi;
        logic lo;
    } lim_res_t;

    // Raise to the floor first, then cut at the ceiling: ceiling wins when inverted.
    function automatic lim_res_t clamp_word(ftw_t w, ftw_t ceil_v, ftw_t floor_v);
        lim_res_t r;
        ftw_t     raised;
        logic     below;
        below  = (w < floor_v);
        raised = below ? floor_v : w;
        r.hi   = (raised > ceil_v);
        r.lo   = below && !r.hi;
        r.word = r.hi ? ceil_v : raised;
        return r;
    endfunction
endpackage

// File: rtl/ftw_limiter.sv
module ftw_limiter
    import dds_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ftw_t     ftw_in,
    input  logic     ftw_valid,
    input  logic     lim_wr,
    input  logic     lim_sel,
    input  ftw_t     lim_data,
    output ftw_t     lim_up,
    output ftw_t     lim_lo,
    output ftw_t     ftw_q,
    output logic     clip_hi,
    output logic     clip_lo
);
    localparam ftw_t NYQ_WORD = ftw_t'(1) << (FTW_W - 1);

    lim_res_t res;

    always_comb res = clamp_word(ftw_in, lim_up, lim_lo);

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_up <= NYQ_WORD;
            lim_lo <= '0;
        end else if (lim_wr) begin
            if (lim_sel_e'(lim_sel) == SEL_CEIL) lim_up <= lim_data;
            else                                 lim_lo <= lim_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ftw_q   <= '0;
            clip_hi <= 1'b0;
            clip_lo <= 1'b0;
        end else if (ftw_valid) begin
            ftw_q   <= res.word;
            clip_hi <= res.hi;
            clip_lo <= res.lo;
        end
    end
endmodule

// File: rtl/phase_acc.sv
module phase_acc
    import dds_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ftw_t step,
    output ftw_t phase
);
    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + step;
    end
endmodule

// File: rtl/sine_lut.sv
module sine_lut #(
    parameter int PH_W  = 12,
    parameter int AMP_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PH_W-1:0]  ph,
    output logic [AMP_W-1:0] amp
);
    localparam int  Q_W     = PH_W - 2;
    localparam int  DEPTH   = 1 << Q_W;
    localparam int  AMP_MAX = (1 << (AMP_W - 1)) - 1;
    localparam real TWO_PI  = 6.283185307179586;

    logic [AMP_W-2:0] rom [DEPTH];

    // Quarter wave sampled at half-step offsets so the mirror is exact.
    for (genvar k = 0; k < DEPTH; k++) begin : g_rom
        localparam real ANG = TWO_PI * (k + 0.5) / (4.0 * DEPTH);
        localparam int  VAL = $rtoi(AMP_MAX * $sin(ANG) + 0.5);
        assign rom[k] = (AMP_W-1)'(VAL);
    end

    logic [Q_W-1:0]  idx_q;
    logic            neg_q;
    logic [AMP_W-1:0] mag;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            neg_q <= 1'b0;
        end else begin
            idx_q <= ph[PH_W-2] ? ~ph[Q_W-1:0] : ph[Q_W-1:0];
            neg_q <= ph[PH_W-1];
        end
    end

    always_comb mag = {1'b0, rom[idx_q]};

    always_ff @(posedge clk) begin
        if (rst) amp <= '0;
        else     amp <= neg_q ? (~mag + 1'b1) : mag;
    end
endmodule

// File: rtl/dds_tuning_core.sv
module dds_tuning_core
    import dds_pkg::*;
#(
    parameter int PH_BITS  = dds_pkg::PH_W,
    parameter int AMP_BITS = dds_pkg::AMP_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [FTW_W-1:0]    ftw_in,
    input  logic                ftw_valid,
    input  logic                lim_wr,
    input  logic                lim_sel,
    input  logic [FTW_W-1:0]    lim_data,
    output logic [FTW_W-1:0]    phase,
    output logic [AMP_BITS-1:0] amp,
    output logic                clip_hi,
    output logic                clip_lo
);
    ftw_t lim_up;
    ftw_t lim_lo;
    ftw_t ftw_q;

    ftw_limiter u_lim (
        .clk(clk), .rst(rst), .ftw_in(ftw_in), .ftw_valid(ftw_valid),
        .lim_wr(lim_wr), .lim_sel(lim_sel), .lim_data(lim_data),
        .lim_up(lim_up), .lim_lo(lim_lo), .ftw_q(ftw_q),
        .clip_hi(clip_hi), .clip_lo(clip_lo)
    );

    phase_acc u_acc (
        .clk(clk), .rst(rst), .step(ftw_q), .phase(phase)
    );

    sine_lut #(.PH_W(PH_BITS), .AMP_W(AMP_BITS)) u_lut (
        .clk(clk), .rst(rst), .ph(phase[FTW_W-1 -: PH_BITS]), .amp(amp)
    );
endmodule

// File: rtl/dds_tuning_core_chk.sv
module dds_tuning_core_chk
    import dds_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic ftw_valid,
    input ftw_t lim_up,
    input ftw_t lim_lo,
    input ftw_t ftw_q,
    input ftw_t phase,
    input logic clip_hi,
    input logic clip_lo
);
    assert_ceiling_R2: assert property (@(posedge clk) disable iff (rst)
        ftw_valid |=> ftw_q <= $past(lim_up));

    assert_floor_R3: assert property (@(posedge clk) disable iff (rst)
        (ftw_valid && lim_lo <= lim_up) |=> ftw_q >= $past(lim_lo));

    assert_flags_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(clip_hi && clip_lo));

    assert_word_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !ftw_valid |=> $stable(ftw_q));

    assert_accumulate_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> phase == $past(phase) + $past(ftw_q));

    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !ftw_valid |=> ($stable(clip_hi) && $stable(clip_lo)));
endmodule

bind dds_tuning_core dds_tuning_core_chk u_chk (
    .clk(clk), .rst(rst), .ftw_valid(ftw_valid), .lim_up(lim_up),
    .lim_lo(lim_lo), .ftw_q(ftw_q), .phase(phase),
    .clip_hi(clip_hi), .clip_lo(clip_lo)
);

// File: tb/sim_dds_tuning_core.sv
module sim_dds_tuning_core;
    localparam logic [47:0] NYQ  = 48'h8000_0000_0000;
    localparam logic [63:0] FULL = 64'd1 << 48;
    localparam logic [47:0] NOM  = 48'(FULL * 150 / 1000);
    localparam logic [47:0] OFF  = 48'(FULL * 49 / 10000);
    localparam logic [47:0] NU   = NOM + OFF;
    localparam logic [47:0] NL   = NOM - OFF;
    localparam real         PI2  = 6.283185307179586;

    typedef struct packed {
        logic [47:0] up;
        logic [47:0] lo;
        logic [47:0] w;
        logic [47:0] exp_w;
        logic        hi;
        logic        lf;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{NYQ, 48'd0, 48'd1234567, 48'd1234567, 1'b0, 1'b0},  // R4 wide
        '{NU,  NL,    NOM,         NOM,         1'b0, 1'b0},  // R4 narrow
        '{NU,  NL,    NU + 1,      NU,          1'b1, 1'b0},  // R2
        '{NU,  NL,    NL - 1,      NL,          1'b0, 1'b1},  // R3
        '{NU,  NL,    NU,          NU,          1'b0, 1'b0},  // R4 edge
        '{NU,  NL,    NL,          NL,          1'b0, 1'b0},  // R4 edge
        '{NU,  NL,    48'hFFFF_FFFF_FFFF, NU,   1'b1, 1'b0},  // R2 max
        '{NU,  NL,    48'd0,       NL,          1'b0, 1'b1},  // R3 zero
        '{48'd500, 48'd1000, 48'd200, 48'd500,  1'b1, 1'b0},  // R5
        '{48'd500, 48'd1000, 48'd700, 48'd500,  1'b1, 1'b0}   // R5
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [47:0] ftw_in = '0;
    logic        ftw_valid = 1'b0;
    logic        lim_wr = 1'b0;
    logic        lim_sel = 1'b0;
    logic [47:0] lim_data = '0;
    logic [47:0] phase;
    logic [13:0] amp;
    logic        clip_hi, clip_lo;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    dds_tuning_core u0 (
        .clk(clk), .rst(rst), .ftw_in(ftw_in), .ftw_valid(ftw_valid),
        .lim_wr(lim_wr), .lim_sel(lim_sel), .lim_data(lim_data),
        .phase(phase), .amp(amp), .clip_hi(clip_hi), .clip_lo(clip_lo)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int sine_ref(input int p);
        real v;
        v = 8191.0 * $sin(PI2 * (p + 0.5) / 4096.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ftw_valid = 1'b0; lim_wr = 1'b0;
        repeat (3) @(negedge clk);
        check(phase == 0, "R1 phase", 64'(phase), 0);
        check(amp == 0, "R1 amp", 64'(amp), 0);
        check({clip_hi, clip_lo} == 2'b00, "R1 flags", 64'({clip_hi, clip_lo}), 0);
        rst = 1'b0;
    endtask

    task automatic write_lim(input logic sel, input logic [47:0] v);
        lim_wr = 1'b1; lim_sel = sel; lim_data = v;
        @(negedge clk);
        lim_wr = 1'b0;
    endtask

    // Presents w, checks flags one edge later, then the phase step one cycle on.
    task automatic apply(input logic [47:0] w, input logic [47:0] exp_w,
                         input logic ehi, input logic elo, input string tag);
        logic [47:0] p0;
        ftw_in = w; ftw_valid = 1'b1;
        @(negedge clk);
        ftw_valid = 1'b0;
        check({clip_hi, clip_lo} == {ehi, elo}, {tag, " flags"},
              64'({clip_hi, clip_lo}), 64'({ehi, elo}));
        p0 = phase;
        @(negedge clk);
        check(phase - p0 == exp_w, {tag, " step"}, 64'(phase - p0), 64'(exp_w));
    endtask

    initial begin
        logic [47:0] pa;
        int          ph_hist [48];

        do_reset();

        // R1: default ceiling is half the sample rate
        apply(48'hFFFF_FFFF_FFFF, NYQ, 1'b1, 1'b0, "R1 default ceiling");

        // R8: amplitude vs phase two samples earlier
        do_reset();
        ftw_in = (48'd300 << 36) + 48'd12345; ftw_valid = 1'b1;
        @(negedge clk);
        ftw_valid = 1'b0;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            ph_hist[i] = int'(phase[47:36]);
            if (i >= 2) begin
                int a, e;
                a = int'($signed(amp));
                e = sine_ref(ph_hist[i-2]);
                check((a - e <= 1) && (e - a <= 1), "R8 amp", 64'(a), 64'(e));
            end
        end

        // Vector table: R2 R3 R4 R5 with limits written per entry (R9)
        for (int v = 0; v < NV; v++) begin
            write_lim(1'b1, VEC[v].up);
            write_lim(1'b0, VEC[v].lo);
            apply(VEC[v].w, VEC[v].exp_w, VEC[v].hi, VEC[v].lf, "R2/R3/R4/R5 vec");
        end

        // R6 R10: held word and flags while ftw_valid low
        write_lim(1'b1, NU);
        write_lim(1'b0, NL);
        apply(NU + 1, NU, 1'b1, 1'b0, "R6 load");
        ftw_in = NL - 1;
        repeat (3) @(negedge clk);
        check(clip_hi == 1'b1 && clip_lo == 1'b0, "R10 flags held",
              64'({clip_hi, clip_lo}), 64'h2);
        pa = phase;
        @(negedge clk);
        check(phase - pa == NU, "R6 word held", 64'(phase - pa), 64'(NU));

        // R9: limit write is deferred and leaves phase running
        pa = phase;
        write_lim(1'b1, NU + 100);
        check(phase - pa == NU, "R9 no early effect", 64'(phase - pa), 64'(NU));
        check(clip_hi == 1'b1, "R9 flags unchanged", 64'(clip_hi), 1);
        apply(NU + 1000, NU + 100, 1'b1, 1'b0, "R9 new ceiling");
        write_lim(1'b0, NOM);
        apply(NL, NOM, 1'b0, 1'b1, "R9 new floor");

        // R7: wrap modulo 2^48
        do_reset();
        ftw_in = NYQ; ftw_valid = 1'b1;
        @(negedge clk);
        ftw_valid = 1'b0;
        check(phase == 0, "R7 start", 64'(phase), 0);
        @(negedge clk);
        check(phase == NYQ, "R7 half", 64'(phase), 64'(NYQ));
        @(negedge clk);
        check(phase == 0, "R7 wrap", 64'(phase), 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule